// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, counter-based model of a retriggerable monostable. Three asynchronous control pins (an active-low trigger `trig_a_n`, an active-high trigger `trig_b` and an active-low clear `clr_n`) are brought into the clock domain through two-flop synchronisers. Edges are found by comparing each synchronised sample with the one taken a cycle earlier. A qualified trigger launches a timed pulse on `q`, with `q_n` as its complement.

Each pulse has two phases. A short discharge phase of `DIS_LEN` cycles comes first and sets the minimum spacing between useful retriggers. A charge phase follows, and its length comes from the `width_cycles` input. A trigger that arrives during the charge phase restarts the sequence from the discharge phase, so the pulse is stretched. A trigger that arrives during the discharge phase is dropped. Holding clear low parks the block in idle with `q` low. All pins are plain level controls. There is no streaming data path, so no valid/ready handshake and no back-pressure apply.

Top module: `retrig_oneshot`

## Requirements
- R1: With `trig_a_n` low, a rising edge on `trig_b` is a valid trigger.
- R2: With `trig_b` high, a falling edge on `trig_a_n` is a valid trigger.
- R3: With `trig_a_n` low and `trig_b` high, a rising edge on `clr_n` is a valid trigger.
- R4: No other pattern triggers. This covers a rising `trig_b` while `trig_a_n` is high, a falling `trig_a_n` while `trig_b` is low, and a rising `clr_n` while `trig_a_n` is high.
- R5: `q` goes high after the third rising clock edge that follows a triggering input change: two synchroniser edges, then one state edge.
- R6: From idle, `q` stays high for exactly `DIS_LEN + W` cycles. W is `width_cycles`, and a value of 0 acts as 1.
- R7: A valid trigger seen during the charge phase returns the block to the start of the discharge phase. `q` stays high and falls `3 + DIS_LEN + W` edges after the retriggering input change.
- R8: A valid trigger seen during the discharge phase has no effect on the timing.
- R9: While the synchronised `clr_n` is low, the block is idle, `q` is low and every trigger is ignored. `q` falls within three edges of `clr_n` going low.
- R10: `q_n` is always the inverse of `q`.
- R11: A synchronous active-high `rst` forces idle with `q` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_a_n | input | 1 | Trigger input, active on its falling edge or low level |
| trig_b | input | 1 | Trigger input, active on its rising edge or high level |
| clr_n | input | 1 | Clear, active low; its rising edge can also trigger |
| width_cycles | input | CNT_W | Charge-phase length in clock cycles (0 acts as 1) |
| q | output | 1 | Pulse output |
| q_n | output | 1 | Inverse of `q` |

## Verification
Each of the three trigger conditions is driven from idle, and the bench measures both the rise edge and the fall edge. This separates a correct decode from one that swaps edge and level roles. Near-miss patterns are also driven, such as an edge arriving with the other input at the wrong level, to confirm that the decode is not too loose. Second triggers are placed in the charge phase and in the discharge phase, and the fall edge shows whether the counter was restarted. Clear is exercised mid-pulse, with triggers held off while it is low and a trigger fired by its release, and widths of 0, 1 and 8 probe the terminal count.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DIS  = 2'd1,
    PH_CHG  = 2'd2
  } phase_t;
endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else if (i == 0) stg[i] <= d;
      else stg[i] <= stg[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/oneshot_trig.sv
module oneshot_trig (
  input  logic clk,
  input  logic rst,
  input  logic a_n_s,
  input  logic b_s,
  input  logic clr_n_s,
  output logic trig,
  output logic clr_lvl
);
  logic a_prev, b_prev, clr_prev;
  logic a_fall, b_rise, clr_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev   <= 1'b1;
      b_prev   <= 1'b0;
      clr_prev <= 1'b1;
    end else begin
      a_prev   <= a_n_s;
      b_prev   <= b_s;
      clr_prev <= clr_n_s;
    end
  end

  assign a_fall   = a_prev & ~a_n_s;
  assign b_rise   = b_s & ~b_prev;
  assign clr_rise = clr_n_s & ~clr_prev;

  // three qualifying conditions
  assign trig = (~a_n_s & b_rise) | (b_s & a_fall) | (~a_n_s & b_s & clr_rise);
  assign clr_lvl = clr_n_s;
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CW = 8,
  parameter int DIS_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             clr_lvl,
  input  logic [CNT_W-1:0] width_cycles,
  output phase_t           phase,
  output logic [CW-1:0]    cnt
);
  localparam logic [CW-1:0] DIS_LAST = CW'(DIS_LEN - 1);

  logic [CW-1:0] chg_last;
  assign chg_last = (width_cycles == '0) ? '0 : CW'(width_cycles) - CW'(1);

  always_ff @(posedge clk) begin
    if (rst || !clr_lvl) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (trig) begin
            phase <= PH_DIS;
            cnt   <= '0;
          end
        end
        PH_DIS: begin
          // triggers are not looked at here
          if (cnt == DIS_LAST) begin
            phase <= PH_CHG;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_CHG: begin
          if (trig) begin
            phase <= PH_DIS;
            cnt   <= '0;
          end else if (cnt >= chg_last) begin
            phase <= PH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIS_LEN = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_a_n,
  input  logic             trig_b,
  input  logic             clr_n,
  input  logic [CNT_W-1:0] width_cycles,
  output logic             q,
  output logic             q_n
);
  localparam int DIS_W = $clog2(DIS_LEN + 1);
  localparam int CW = (CNT_W > DIS_W) ? CNT_W : DIS_W;

  logic [2:0] pins_s;
  logic       trig_hit;
  logic       clr_lvl;
  phase_t     phase;
  logic [CW-1:0] cnt;

  oneshot_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)
  ) u_sync (
    .clk(clk), .rst(rst),
    .d({clr_n, trig_b, trig_a_n}),
    .q(pins_s)
  );

  oneshot_trig u_trig (
    .clk(clk), .rst(rst),
    .a_n_s(pins_s[0]), .b_s(pins_s[1]), .clr_n_s(pins_s[2]),
    .trig(trig_hit), .clr_lvl(clr_lvl)
  );

  oneshot_timer #(
    .CNT_W(CNT_W), .CW(CW), .DIS_LEN(DIS_LEN)
  ) u_timer (
    .clk(clk), .rst(rst),
    .trig(trig_hit), .clr_lvl(clr_lvl),
    .width_cycles(width_cycles),
    .phase(phase), .cnt(cnt)
  );

  assign q   = (phase != PH_IDLE);
  assign q_n = ~q;
endmodule

// File: rtl/oneshot_checker.sv
module oneshot_checker
  import oneshot_pkg::*;
#(
  parameter int CW = 8,
  parameter int DIS_LEN = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          q,
  input logic          q_n,
  input logic          trig,
  input logic          clr_lvl,
  input phase_t        phase,
  input logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] DIS_LAST = CW'(DIS_LEN - 1);

  a_r10_complement: assert property (@(posedge clk) q_n == ~q);

  a_r11_reset_idle: assert property (@(posedge clk) rst |=> !q);

  a_r9_clear_idle: assert property (@(posedge clk) disable iff (rst)
    !clr_lvl |=> (phase == PH_IDLE));

  a_r5_rise_needs_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(trig));

  a_r7_charge_restart: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CHG && trig && clr_lvl) |=> (phase == PH_DIS && cnt == '0));

  a_r8_discharge_steady: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DIS && cnt != DIS_LAST && clr_lvl)
      |=> (phase == PH_DIS && cnt == $past(cnt) + CW'(1)));
endmodule

bind retrig_oneshot oneshot_checker #(.CW(CW), .DIS_LEN(DIS_LEN)) u_chk (
  .clk(clk), .rst(rst), .q(q), .q_n(q_n), .trig(trig_hit),
  .clr_lvl(clr_lvl), .phase(phase), .cnt(cnt)
);

// File: tb/retrig_oneshot_bench.sv
`timescale 1ns/1ps
module retrig_oneshot_bench;
  localparam int CNT_W = 8;
  localparam int DL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_n = 1'b1;
  logic b = 1'b0;
  logic clr_n = 1'b1;
  logic [CNT_W-1:0] wid = 8'd8;
  logic q, q_n;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  retrig_oneshot #(.CNT_W(CNT_W), .DIS_LEN(DL), .SYNC_STAGES(2)) u_retrig_oneshot (
    .clk(clk), .rst(rst), .trig_a_n(a_n), .trig_b(b), .clr_n(clr_n),
    .width_cycles(wid), .q(q), .q_n(q_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one edge, sample at the negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (q_n !== ~q) begin
      n_chk++; n_bad++;
      $display("FAIL R10: q=%0b q_n=%0b expected inverse", q, q_n);
    end
  endtask

  // edges (counted from start) until q rises, then until q falls
  task automatic measure(input int start, output int rise_e, output int fall_e);
    int n = start;
    rise_e = -1; fall_e = -1;
    for (int i = 0; i < 400; i++) begin
      step(); n++;
      if (rise_e < 0 && q) rise_e = n;
      if (!q && (rise_e >= 0 || start > 0)) begin fall_e = n; break; end
      if (rise_e < 0 && n > 20) break;
    end
  endtask

  task automatic quiet(input string req, input int cycles);
    int hi = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (q) hi++;
    end
    check(req, hi, 0);
  endtask

  task automatic settle(input logic an, input logic bv, input logic cl);
    a_n = an; b = bv; clr_n = cl;
    for (int i = 0; i < 6; i++) step();
  endtask

  task automatic t_reset();
    check("R11 q low after reset", int'(q), 0);
    check("R10 q_n high after reset", int'(q_n), 1);
  endtask

  task automatic t_r1(input int w, input int wexp);
    int r, f;
    wid = CNT_W'(w);
    settle(1'b0, 1'b0, 1'b1);
    b = 1'b1;
    measure(0, r, f);
    check("R1/R5 rise edge", r, 3);
    check("R1/R6 fall edge", f, 3 + DL + wexp);
  endtask

  task automatic t_r2();
    int r, f;
    wid = 8'd8;
    settle(1'b1, 1'b1, 1'b1);
    a_n = 1'b0;
    measure(0, r, f);
    check("R2 rise edge", r, 3);
    check("R2/R6 fall edge", f, 3 + DL + 8);
  endtask

  task automatic t_r4();
    settle(1'b1, 1'b0, 1'b1);
    b = 1'b1;                       // B rise with A high
    quiet("R4 B rise with A high", 10);
    settle(1'b1, 1'b0, 1'b1);
    a_n = 1'b0;                     // A fall with B low
    quiet("R4 A fall with B low", 10);
    settle(1'b1, 1'b1, 1'b0);
    clr_n = 1'b1;                   // clear rise with A high
    quiet("R4 clear rise with A high", 10);
  endtask

  task automatic t_r7();
    int r, f;
    wid = 8'd8;
    settle(1'b0, 1'b0, 1'b1);
    b = 1'b1;
    for (int i = 0; i < 3 + DL + 2; i++) step();
    check("R7 q high in charge phase", int'(q), 1);
    b = 1'b0;
    step();
    b = 1'b1;                       // retrigger, counted from here
    measure(0, r, f);
    check("R7 q stays high", r, 1);
    check("R7 fall edge after retrigger", f, 3 + DL + 8);
  endtask

  task automatic t_r8();
    int r, f;
    wid = 8'd8;
    settle(1'b0, 1'b0, 1'b1);
    b = 1'b1; step();               // edge 1
    b = 1'b0; step();               // edge 2
    b = 1'b1;                       // second trigger lands in discharge
    measure(2, r, f);
    check("R8 rise edge", r, 3);
    check("R8 fall edge unchanged", f, 3 + DL + 8);
  endtask

  task automatic t_r9_r3();
    int r, f;
    wid = 8'd8;
    settle(1'b0, 1'b0, 1'b1);
    b = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check("R9 q high before clear", int'(q), 1);
    clr_n = 1'b0;
    measure(0, r, f);
    check("R9 q falls after clear", f, 3);
    b = 1'b0; step(); step();
    b = 1'b1;                       // would trigger, clear holds it off
    quiet("R9 trigger ignored in clear", 10);
    clr_n = 1'b1;                   // A low, B high: clear release triggers
    measure(0, r, f);
    check("R3 rise edge", r, 3);
    check("R3 fall edge", f, 3 + DL + 8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_r1(8, 8);
    t_r1(1, 1);
    t_r1(0, 1);
    t_r2();
    t_r4();
    t_r7();
    t_r8();
    t_r9_r3();
    rst = 1'b1; a_n = 1'b1; b = 1'b0; clr_n = 1'b1;
    step();
    rst = 1'b0;
    step();
    check("R11 q low after second reset", int'(q), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule